// File: doc/BRIEF.md
# Inter-Core Mailbox Bank

The block holds sixteen 32-bit mailboxes, four for each of four cores, for signalling between processors. A sender posts a message by writing ones into the target mailbox through a set address. The bits written are ORed into the mailbox, so several senders can post without a read-modify-write. The owning core reads the mailbox through a clear address. It acknowledges messages by writing ones to that same address, which clears only those bits. Each mailbox bit is a separate message type, so one mailbox carries up to 32 kinds of message at once.

Every mailbox drives a nonzero flag. The interrupt router outside this block uses that flag to raise the mailbox pending bit of the owning core, at position 4+m for mailbox m. The register side has a configurable number of write ports, two by default, so two agents can write in the same cycle. It has one read port with one cycle of latency.

Top module: `mbx_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every mailbox is cleared to zero. After that edge mbx_flag is all zero and rd_data is zero.
- R2: A write with wr_en high to byte address 0x80 + 16n + 4m ORs the write data into mailbox m of core n after the clock edge. This is a set write.
- R3: A write to byte address 0xC0 + 16n + 4m clears exactly the bits of mailbox m of core n that are 1 in the write data, and leaves every other bit of that mailbox unchanged. This is a clear write.
- R4: When rd_en is high with a clear address, rd_data shows the contents of that mailbox from the cycle after the edge. The value returned is the one held before any write applied at that same edge.
- R5: When rd_en is high with a set address, or with any address outside both windows, rd_data becomes zero after the edge. While rd_en is low, rd_data holds its last value.
- R6: Bit 4n+m of mbx_flag is 1 exactly when mailbox m of core n is nonzero. It follows the mailbox contents in the same cycle.
- R7: When one port sets a bit and another port clears the same bit of the same mailbox in the same cycle, the set wins. The new value is (old & ~clear) | set.
- R8: Set writes from several ports to the same mailbox in the same cycle are all ORed in.
- R9: A write whose address has nonzero bits [1:0], or lies outside both windows, changes no mailbox.
- R10: A write to one mailbox leaves all other mailboxes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | NUM_WP | Write strobe, one per write port |
| wr_addr | input | NUM_WP*8 | Byte address per write port, port p at bits [8p+7:8p] |
| wr_data | input | NUM_WP*32 | Write data per write port, port p at bits [32p+31:32p] |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Registered read data |
| mbx_flag | output | 16 | Nonzero flag per mailbox, bit 4n+m for mailbox m of core n |

## Verification
The hardest situation to reach is two ports hitting the same mailbox in one cycle: a set racing a clear on overlapping bits, or two sets merging. Random traffic rarely lines up like that on its own. The bench therefore draws both write ports from a small pool of addresses and uses sparse random data, which makes mailbox and bit collisions common. It also adds directed cycles that force a set against a clear on the same bit. Misaligned addresses and addresses outside the windows are mixed into the random traffic, so ignored writes are checked next to live ones.

// File: rtl/mbx_pkg.sv
// Shared definitions for the mailbox bank.
// Assumes byte addressing with 32-bit aligned registers.
package mbx_pkg;

    // Which address window an access falls into
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;

    // Bytes per register
    localparam int unsigned REG_BYTES = 4;

endpackage

// File: rtl/mbx_addr_dec.sv
// Address decoder: classifies a byte address as a set-window hit,
// a clear-window hit or neither, and returns the mailbox index.
// Assumes both windows are NBOX registers long and do not overlap.
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NBOX     = 16,
    parameter int unsigned SET_BASE = 32'h80,
    parameter int unsigned CLR_BASE = 32'hC0,
    localparam int unsigned IDX_W   = (NBOX > 1) ? $clog2(NBOX) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned WIN_BYTES = NBOX * REG_BYTES;

    logic [31:0] a_ext;
    logic [31:0] off_set;
    logic [31:0] off_clr;

    assign a_ext   = 32'(addr);
    assign off_set = a_ext - SET_BASE;
    assign off_clr = a_ext - CLR_BASE;

    // Window and index selection
    always_comb begin
        win = WIN_NONE;
        idx = '0;
        if (a_ext[1:0] == 2'b00) begin
            if (a_ext >= SET_BASE && a_ext < SET_BASE + WIN_BYTES) begin
                win = WIN_SET;
                idx = IDX_W'(off_set >> 2);
            end else if (a_ext >= CLR_BASE && a_ext < CLR_BASE + WIN_BYTES) begin
                win = WIN_CLR;
                idx = IDX_W'(off_clr >> 2);
            end
        end
    end
endmodule

// File: rtl/mbx_cell.sv
// One mailbox register. Clear bits are removed first, then set bits
// are added, so a set racing a clear on the same bit keeps the bit.
// Assumes set_bits and clr_bits are already merged across ports.
module mbx_cell #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] q,
    output logic              nonzero
);
    // Storage update with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_bits) | set_bits;
    end

    // Nonzero flag for the interrupt router
    assign nonzero = |q;
endmodule

// File: rtl/mbx_rd_port.sv
// Registered read port. A clear-window address returns the mailbox
// contents; any other address returns zero. Holds while rd_en is low.
// Assumes the decoder has already classified rd_addr.
module mbx_rd_port
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NBOX   = 16,
    localparam int unsigned IDX_W = (NBOX > 1) ? $clog2(NBOX) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  win_e                   rd_win,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [NBOX*DATA_W-1:0] box_flat,
    output logic [DATA_W-1:0]      rd_data
);
    logic [DATA_W-1:0] sel_word;

    // Mailbox word selection
    always_comb begin
        sel_word = '0;
        if (rd_win == WIN_CLR) sel_word = box_flat[rd_idx*DATA_W +: DATA_W];
    end

    // Read data register
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end
endmodule

// File: rtl/mbx_bank.sv
// Inter-core mailbox bank top. Decodes each write port, merges the
// set and clear masks per mailbox across ports, and holds one
// mbx_cell per mailbox. Box index b = core * BOX_PER_CORE + box.
// Assumes synchronous active-low reset and byte addressing.
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CORES    = 4,
    parameter int unsigned BOX_PER_CORE = 4,
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = 8,
    parameter int unsigned NUM_WP       = 2,
    parameter int unsigned SET_BASE     = 32'h80,
    parameter int unsigned CLR_BASE     = 32'hC0,
    localparam int unsigned NBOX        = NUM_CORES * BOX_PER_CORE,
    localparam int unsigned IDX_W       = (NBOX > 1) ? $clog2(NBOX) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_WP-1:0]        wr_en,
    input  logic [NUM_WP*ADDR_W-1:0] wr_addr,
    input  logic [NUM_WP*DATA_W-1:0] wr_data,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NBOX-1:0]          mbx_flag
);
    win_e                   wp_win [NUM_WP];
    logic [IDX_W-1:0]       wp_idx [NUM_WP];
    logic [NBOX*DATA_W-1:0] box_flat;
    win_e                   rd_win;
    logic [IDX_W-1:0]       rd_idx;

    // One decoder per write port
    for (genvar p = 0; p < NUM_WP; p++) begin : g_wdec
        mbx_addr_dec #(
            .ADDR_W  (ADDR_W),
            .NBOX    (NBOX),
            .SET_BASE(SET_BASE),
            .CLR_BASE(CLR_BASE)
        ) dec_i (
            .addr(wr_addr[p*ADDR_W +: ADDR_W]),
            .win (wp_win[p]),
            .idx (wp_idx[p])
        );
    end

    // One storage cell per mailbox with merged port masks
    for (genvar b = 0; b < NBOX; b++) begin : g_box
        logic [DATA_W-1:0] set_m;
        logic [DATA_W-1:0] clr_m;

        // OR together every port that targets this mailbox
        always_comb begin
            set_m = '0;
            clr_m = '0;
            for (int p = 0; p < NUM_WP; p++) begin
                if (wr_en[p] && wp_idx[p] == IDX_W'(b)) begin
                    if (wp_win[p] == WIN_SET) set_m = set_m | wr_data[p*DATA_W +: DATA_W];
                    if (wp_win[p] == WIN_CLR) clr_m = clr_m | wr_data[p*DATA_W +: DATA_W];
                end
            end
        end

        mbx_cell #(.DATA_W(DATA_W)) cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_bits(set_m),
            .clr_bits(clr_m),
            .q       (box_flat[b*DATA_W +: DATA_W]),
            .nonzero (mbx_flag[b])
        );
    end

    // Read address decode
    mbx_addr_dec #(
        .ADDR_W  (ADDR_W),
        .NBOX    (NBOX),
        .SET_BASE(SET_BASE),
        .CLR_BASE(CLR_BASE)
    ) rdec_i (
        .addr(rd_addr),
        .win (rd_win),
        .idx (rd_idx)
    );

    mbx_rd_port #(
        .DATA_W(DATA_W),
        .NBOX  (NBOX)
    ) rd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_win  (rd_win),
        .rd_idx  (rd_idx),
        .box_flat(box_flat),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mbx_bank_chk.sv
// Property checker for mbx_bank, attached by bind. Watches the ports
// and the mailbox storage; port 0 is the reference writer.
module mbx_bank_chk #(
    parameter int unsigned NBOX     = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_WP   = 2,
    parameter int unsigned SET_BASE = 32'h80,
    parameter int unsigned CLR_BASE = 32'hC0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_WP-1:0]        wr_en,
    input logic [NUM_WP*ADDR_W-1:0] wr_addr,
    input logic [NUM_WP*DATA_W-1:0] wr_data,
    input logic                     rd_en,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [DATA_W-1:0]        rd_data,
    input logic [NBOX-1:0]          mbx_flag,
    input logic [NBOX*DATA_W-1:0]   box_flat
);
    localparam int unsigned SPAN = NBOX * 4;

    logic [31:0] a0;
    logic [31:0] ar;
    logic        p0_set, p0_clr, others_idle, rd_set;
    int unsigned p0_box;

    assign a0          = 32'(wr_addr[ADDR_W-1:0]);
    assign ar          = 32'(rd_addr);
    assign p0_set      = wr_en[0] && a0[1:0] == 2'b00 && a0 >= SET_BASE && a0 < SET_BASE + SPAN;
    assign p0_clr      = wr_en[0] && a0[1:0] == 2'b00 && a0 >= CLR_BASE && a0 < CLR_BASE + SPAN;
    assign p0_box      = p0_set ? (a0 - SET_BASE) / 4 : (a0 - CLR_BASE) / 4;
    assign others_idle = (wr_en >> 1) == '0;
    assign rd_set      = rd_en && ar >= SET_BASE && ar < SET_BASE + SPAN;

    logic              set_q, clr_q, rdset_q;
    int unsigned       box_q;
    logic [DATA_W-1:0] dat_q, old_q;

    // Capture the port-0 write for checking one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q   <= 1'b0;
            clr_q   <= 1'b0;
            rdset_q <= 1'b0;
            box_q   <= 0;
            dat_q   <= '0;
            old_q   <= '0;
        end else begin
            set_q   <= p0_set;
            clr_q   <= p0_clr && others_idle;
            rdset_q <= rd_set;
            box_q   <= p0_box;
            dat_q   <= wr_data[DATA_W-1:0];
            old_q   <= (p0_set || p0_clr) ? box_flat[p0_box*DATA_W +: DATA_W] : '0;
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mbx_flag == '0 && rd_data == '0)); // R1

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_q |-> ((box_flat[box_q*DATA_W +: DATA_W] & dat_q) == dat_q)); // R7

    AST_CLEAR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> (box_flat[box_q*DATA_W +: DATA_W] == (old_q & ~dat_q))); // R3

    AST_SET_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdset_q |-> (rd_data == '0)); // R5

    AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(mbx_flag)); // R6

    AST_IDLE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) |=> $stable(box_flat)); // R10
endmodule

bind mbx_bank mbx_bank_chk #(
    .NBOX    (NBOX),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_WP  (NUM_WP),
    .SET_BASE(SET_BASE),
    .CLR_BASE(CLR_BASE)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .mbx_flag(mbx_flag),
    .box_flat(box_flat)
);

// File: tb/mbx_bank_tb_top.sv
`timescale 1ns/1ps
module mbx_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_en = '0;
    logic [15:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] mbx_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] mdl [16];
    logic [31:0] exp_rd = '0;

    always #4 clk = ~clk;

    mbx_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .mbx_flag(mbx_flag)
    );

    // Classify an address: 1 = set, 2 = clear, 0 = none
    function automatic int kind_of(logic [7:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a >= 8'h80 && a < 8'hC0) return 1;
        if (a >= 8'hC0) return 2;
        return 0;
    endfunction

    function automatic int box_of(logic [7:0] a);
        return int'(a[5:2]);
    endfunction

    function automatic logic [7:0] set_a(int n, int m);
        return 8'(8'h80 + 16 * n + 4 * m);
    endfunction

    function automatic logic [7:0] clr_a(int n, int m);
        return 8'(8'hC0 + 16 * n + 4 * m);
    endfunction

    function automatic logic [15:0] flags_of();
        logic [15:0] f = '0;
        for (int b = 0; b < 16; b++) f[b] = (mdl[b] != 0);
        return f;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic step();
        logic [31:0] s [16];
        logic [31:0] c [16];
        @(posedge clk);
        if (!rst_n) begin
            for (int b = 0; b < 16; b++) mdl[b] = '0;
            exp_rd = '0;
        end else begin
            if (rd_en) exp_rd = (kind_of(rd_addr) == 2) ? mdl[box_of(rd_addr)] : 32'h0;
            for (int b = 0; b < 16; b++) begin s[b] = '0; c[b] = '0; end
            for (int p = 0; p < 2; p++) begin
                if (wr_en[p]) begin
                    int k = kind_of(wr_addr[p*8 +: 8]);
                    int b = box_of(wr_addr[p*8 +: 8]);
                    if (k == 1) s[b] |= wr_data[p*32 +: 32];
                    if (k == 2) c[b] |= wr_data[p*32 +: 32];
                end
            end
            for (int b = 0; b < 16; b++) mdl[b] = (mdl[b] & ~c[b]) | s[b];
        end
        @(negedge clk);
        chk("R6", {16'h0, mbx_flag}, {16'h0, flags_of()});
        chk("R4", rd_data, exp_rd);
    endtask

    task automatic wr2(bit e0, logic [7:0] a0, logic [31:0] d0,
                       bit e1, logic [7:0] a1, logic [31:0] d1);
        wr_en = {e1, e0}; wr_addr = {a1, a0}; wr_data = {d1, d0};
        step();
        wr_en = '0;
    endtask

    task automatic rd(logic [7:0] a);
        rd_en = 1'b1; rd_addr = a;
        step();
        rd_en = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    logic [7:0] pool [8];

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 16; b++) mdl[b] = '0;
        @(negedge clk);
        step(); step();
        chk("R1", {16'h0, mbx_flag}, 32'h0);
        chk("R1", rd_data, 32'h0);
        rst_n = 1'b1;

        // R2: set write ORs into core 2 box 1 (flag bit 9)
        wr2(1, set_a(2, 1), 32'h11, 0, 8'h0, 0);
        rd(clr_a(2, 1));
        chk("R2", rd_data, 32'h11);
        chk("R6", {31'h0, mbx_flag[9]}, 32'h1);
        wr2(1, set_a(2, 1), 32'h100, 0, 8'h0, 0);
        rd(clr_a(2, 1));
        chk("R2", rd_data, 32'h111);

        // R3: clear exactly the ones written
        wr2(0, 8'h0, 0, 1, clr_a(2, 1), 32'h10);
        rd(clr_a(2, 1));
        chk("R3", rd_data, 32'h101);

        // R5: set-window read returns zero
        rd(set_a(2, 1));
        chk("R5", rd_data, 32'h0);

        // R7: set and clear on the same bit in one cycle
        wr2(1, set_a(2, 1), 32'h2, 1, clr_a(2, 1), 32'h3);
        rd(clr_a(2, 1));
        chk("R7", rd_data, 32'h102);

        // R8: two sets merge
        wr2(1, set_a(3, 3), 32'h0A, 1, set_a(3, 3), 32'h50);
        rd(clr_a(3, 3));
        chk("R8", rd_data, 32'h5A);

        // R9: misaligned and low addresses are ignored
        wr2(1, 8'h81, 32'hFFFF_FFFF, 1, 8'h10, 32'hFFFF_FFFF);
        rd(clr_a(0, 0));
        chk("R9", rd_data, 32'h0);
        chk("R9", {16'h0, mbx_flag}, {16'h0, 16'h8200});

        // R4: read returns the value before a same-cycle write
        rd_en = 1'b1; rd_addr = clr_a(3, 3);
        wr2(1, clr_a(3, 3), 32'h5A, 0, 8'h0, 0);
        rd_en = 1'b0;
        chk("R4", rd_data, 32'h5A);
        chk("R6", {31'h0, mbx_flag[15]}, 32'h0);

        // Random traffic over a narrow address pool
        pool[0] = set_a(1, 2); pool[1] = clr_a(1, 2);
        pool[2] = set_a(0, 3); pool[3] = clr_a(0, 3);
        pool[4] = 8'h92;       pool[5] = 8'h3C;
        pool[6] = set_a(1, 2); pool[7] = clr_a(1, 2);
        for (int i = 0; i < 400; i++) begin
            wr_en   = 2'($urandom);
            wr_addr = {pool[$urandom % 8], pool[$urandom % 8]};
            wr_data = {$urandom & $urandom, $urandom & $urandom};
            rd_en   = 1'($urandom);
            rd_addr = (($urandom % 4) == 0) ? pool[$urandom % 8] : 8'(8'h80 + 4 * ($urandom % 32));
            step();
        end
        wr_en = '0; rd_en = 1'b0;

        // R10: every mailbox matches the model after the random run
        for (int b = 0; b < 16; b++) begin
            rd(8'(8'hC0 + 4 * b));
            chk("R10", rd_data, mdl[b]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule